// File: doc/BRIEF.md
# Two-Phase Piezo Bridge Drive Sequencer

This block produces the switch timing for a two-phase piezoelectric linear motor. Each motor phase has its own full bridge. Each bridge has two legs, and each leg has one high-side and one low-side switch, so the block drives eight switch signals in total. The block takes plain register values: a period count, a duty count, a phase-offset count, a direction bit, a dead-time count and a pulse count. From these it runs the motor for the requested number of drive periods and then stops. The caller sets the drive frequency with the period count: a higher count gives a slower drive clock relative to the input clock. The number of periods sets how far the motor travels.

The two phases run on one shared counter that steps through each period. Phase B is shifted against phase A by the offset count, and the direction bit sets whether B lags or leads A. Each leg inserts a both-off gap whenever its target side changes. When the block is idle, stopped or in standby, every switch output is low.

Top module: `pzdrv_seq`

## Requirements
- R1: After reset, all eight switch outputs, `busy_o` and `done_o` are low.
- R2: A run begins only when `start_i` is high, `standby_i` is low, `busy_o` is low and `pulses_i` is non-zero. `busy_o` rises one cycle after such a start. A start while busy, or with `pulses_i` equal to zero, has no effect.
- R3: The period is P clock cycles, where P is `period_i`, and any value below 2 is treated as 2. A counter steps from 0 to P-1 in each period. Phase A's level is high while the counter is below `duty_i`.
- R4: Leg index 0 and leg index 1 belong to phase A, and leg indices 2 and 3 belong to phase B. An even leg targets its high side when its phase level is high. An odd leg targets the opposite side of its even partner.
- R5: Phase B's level is high while its position is below `duty_i`. The position is (count − offset) mod P when `reverse_i` is 0, and (count + offset) mod P when `reverse_i` is 1. An offset of P or more is taken as 0.
- R6: The high-side and low-side outputs of one leg are never high in the same cycle.
- R7: When a leg's target side changes, both of its switches are off for D+1 cycles before the new side turns on, where D is the dead-time count. A leg starting a run waits the same D+1 off cycles before its first turn-on.
- R8: A run lasts exactly N periods, where N is `pulses_i` as sampled at start. In the cycle after the final count of the last period, `busy_o` falls and `done_o` is high for exactly one cycle.
- R9: Starting one cycle after `busy_o` falls, all switch outputs stay low until the next run drives them.
- R10: While `standby_i` is high, all switch outputs are low in that same cycle. A run in progress is aborted without `done_o`, and a start request is ignored.
- R11: The period, duty, offset, direction and dead-time inputs are captured only at start and at each period boundary. A change in the middle of a period takes effect at the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Drive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Power-down request; forces all outputs low |
| start_i | input | 1 | Begins a run of `pulses_i` periods |
| period_i | input | CNT_W | Period length in clock cycles |
| duty_i | input | CNT_W | Cycles per period that a phase level is high |
| offset_i | input | CNT_W | Phase B shift against phase A, in cycles |
| reverse_i | input | 1 | 0: phase B lags A; 1: phase B leads A |
| deadtime_i | input | DT_W | Extra both-off cycles per switch-over |
| pulses_i | input | PULSE_W | Number of periods in a run |
| hs_o | output | 4 | High-side switch per leg (A0, A1, B0, B1) |
| ls_o | output | 4 | Low-side switch per leg (A0, A1, B0, B1) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run completes |

## Verification
On every cycle, the assertions check that no leg has both of its switches on, and that a side turns on only after a cycle in which the opposite side was off. They also check that the period counter stays below the captured period, that `done_o` is a single pulse that follows a busy cycle, and that the outputs stay low after the block goes idle or a leg is disabled. The exact length of each dead-time gap, the phase B position in both directions, and the run length counted in cycles can only be shown by the bench's scenarios. The same holds for a parameter change landing at the next boundary and for a start being ignored.

// File: rtl/pzdrv_pkg.sv
package pzdrv_pkg;

    localparam int NUM_LEGS = 4;

    // Even legs follow their phase level, odd legs are the complement.
    // Legs 0/1 belong to phase A, legs 2/3 to phase B.
    function automatic logic leg_target(input logic lvl_a, input logic lvl_b, input logic [1:0] idx);
        logic lvl;
        lvl = idx[1] ? lvl_b : lvl_a;
        return lvl ^ idx[0];
    endfunction

endpackage

// File: rtl/pzdrv_timebase.sv
module pzdrv_timebase #(
    parameter int CNT_W   = 12,
    parameter int PULSE_W = 16,
    parameter int DT_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               standby_i,
    input  logic               start_i,
    input  logic [CNT_W-1:0]   period_i,
    input  logic [CNT_W-1:0]   duty_i,
    input  logic [CNT_W-1:0]   offset_i,
    input  logic               reverse_i,
    input  logic [DT_W-1:0]    deadtime_i,
    input  logic [PULSE_W-1:0] pulses_i,
    output logic               run_o,
    output logic               done_o,
    output logic               lvl_a_o,
    output logic               lvl_b_o,
    output logic [DT_W-1:0]    dt_o
);

    localparam logic [CNT_W-1:0]   MIN_PER = CNT_W'(2);
    localparam logic [PULSE_W-1:0] LAST    = PULSE_W'(1);

    typedef struct packed {
        logic               run;
        logic               done;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   per;
        logic [CNT_W-1:0]   duty;
        logic [CNT_W-1:0]   off;
        logic               rev;
        logic [DT_W-1:0]    dt;
        logic [PULSE_W-1:0] rem;
    } tbase_t;

    tbase_t st_d, st_q;

    logic [CNT_W-1:0] per_in, off_in;
    logic [CNT_W:0]   cnt_x, off_x, per_x, sum_x, pos_b;
    logic             wrap;

    // Sanitised shadow values from the register inputs
    always_comb begin
        per_in = (period_i < MIN_PER) ? MIN_PER : period_i;
        off_in = (offset_i >= per_in) ? '0 : offset_i;
    end

    // Phase B position within the period
    always_comb begin
        cnt_x = {1'b0, st_q.cnt};
        off_x = {1'b0, st_q.off};
        per_x = {1'b0, st_q.per};
        sum_x = cnt_x + off_x;
        if (st_q.rev) begin
            pos_b = (sum_x >= per_x) ? (sum_x - per_x) : sum_x;
        end else begin
            pos_b = (cnt_x >= off_x) ? (cnt_x - off_x) : (cnt_x + per_x - off_x);
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        wrap      = (st_q.cnt == st_q.per - CNT_W'(1));
        if (!st_q.run) begin
            if (start_i && !standby_i && (pulses_i != '0)) begin
                st_d.run  = 1'b1;
                st_d.cnt  = '0;
                st_d.rem  = pulses_i;
                st_d.per  = per_in;
                st_d.duty = duty_i;
                st_d.off  = off_in;
                st_d.rev  = reverse_i;
                st_d.dt   = deadtime_i;
            end
        end else if (standby_i) begin
            st_d.run = 1'b0;
        end else if (wrap) begin
            if (st_q.rem == LAST) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.rem  = st_q.rem - LAST;
                st_d.cnt  = '0;
                st_d.per  = per_in;
                st_d.duty = duty_i;
                st_d.off  = off_in;
                st_d.rev  = reverse_i;
                st_d.dt   = deadtime_i;
            end
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.per <= MIN_PER;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o   = st_q.run;
    assign done_o  = st_q.done;
    assign lvl_a_o = (st_q.cnt < st_q.duty);
    assign lvl_b_o = (pos_b < {1'b0, st_q.duty});
    assign dt_o    = st_q.dt;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt < st_q.per)); // R3
    AST_REM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.rem != '0)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done); // R8
    AST_STBY_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (!st_q.run && !st_q.done)); // R10

endmodule

// File: rtl/pzdrv_leg.sv
module pzdrv_leg #(
    parameter int DT_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            want_i,
    input  logic [DT_W-1:0] dt_i,
    output logic            hs_o,
    output logic            ls_o
);

    typedef struct packed {
        logic            armed;
        logic            side;
        logic            hs;
        logic            ls;
        logic [DT_W-1:0] tmr;
    } leg_t;

    leg_t lg_d, lg_q;

    always_comb begin
        lg_d    = lg_q;
        lg_d.hs = 1'b0;
        lg_d.ls = 1'b0;
        if (!en_i) begin
            lg_d.armed = 1'b0;
            lg_d.tmr   = '0;
            lg_d.side  = want_i;
        end else if (!lg_q.armed || (want_i != lg_q.side)) begin
            lg_d.armed = 1'b1;
            lg_d.side  = want_i;
            lg_d.tmr   = dt_i;
        end else if (lg_q.tmr != '0) begin
            lg_d.tmr = lg_q.tmr - DT_W'(1);
        end else begin
            lg_d.hs = want_i;
            lg_d.ls = !want_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lg_q <= '0;
        end else begin
            lg_q <= lg_d;
        end
    end

    assign hs_o = lg_q.hs;
    assign ls_o = lg_q.ls;

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        !(lg_q.hs && lg_q.ls)); // R6
    AST_HS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lg_q.hs) |-> $past(!lg_q.ls)); // R7
    AST_LS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lg_q.ls) |-> $past(!lg_q.hs)); // R7
    AST_DIS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!lg_q.hs && !lg_q.ls)); // R9

endmodule

// File: rtl/pzdrv_seq.sv
module pzdrv_seq
    import pzdrv_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int PULSE_W = 16,
    parameter int DT_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               standby_i,
    input  logic               start_i,
    input  logic [CNT_W-1:0]   period_i,
    input  logic [CNT_W-1:0]   duty_i,
    input  logic [CNT_W-1:0]   offset_i,
    input  logic               reverse_i,
    input  logic [DT_W-1:0]    deadtime_i,
    input  logic [PULSE_W-1:0] pulses_i,
    output logic [3:0]         hs_o,
    output logic [3:0]         ls_o,
    output logic               busy_o,
    output logic               done_o
);

    logic                run_w, done_w, lvl_a, lvl_b, leg_en;
    logic [DT_W-1:0]     dt_w;
    logic [NUM_LEGS-1:0] hs_w, ls_w;

    pzdrv_timebase #(
        .CNT_W  (CNT_W),
        .PULSE_W(PULSE_W),
        .DT_W   (DT_W)
    ) u_tbase (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_i (standby_i),
        .start_i   (start_i),
        .period_i  (period_i),
        .duty_i    (duty_i),
        .offset_i  (offset_i),
        .reverse_i (reverse_i),
        .deadtime_i(deadtime_i),
        .pulses_i  (pulses_i),
        .run_o     (run_w),
        .done_o    (done_w),
        .lvl_a_o   (lvl_a),
        .lvl_b_o   (lvl_b),
        .dt_o      (dt_w)
    );

    assign leg_en = run_w && !standby_i;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        pzdrv_leg #(.DT_W(DT_W)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (leg_en),
            .want_i(leg_target(lvl_a, lvl_b, 2'(g))),
            .dt_i  (dt_w),
            .hs_o  (hs_w[g]),
            .ls_o  (ls_w[g])
        );
    end

    assign hs_o   = hs_w & {NUM_LEGS{!standby_i}};
    assign ls_o   = ls_w & {NUM_LEGS{!standby_i}};
    assign busy_o = run_w;
    assign done_o = done_w;

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> (hs_o == '0 && ls_o == '0)); // R9
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R8

endmodule

// File: tb/pzdrv_seq_bench.sv
module pzdrv_seq_bench;

    localparam int CNT_W   = 12;
    localparam int PULSE_W = 16;
    localparam int DT_W    = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               standby_i = 1'b0;
    logic               start_i = 1'b0;
    logic [CNT_W-1:0]   period_i = '0;
    logic [CNT_W-1:0]   duty_i = '0;
    logic [CNT_W-1:0]   offset_i = '0;
    logic               reverse_i = 1'b0;
    logic [DT_W-1:0]    deadtime_i = '0;
    logic [PULSE_W-1:0] pulses_i = '0;
    logic [3:0]         hs_o, ls_o;
    logic               busy_o, done_o;

    int    n_run = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    always #4 clk = ~clk;

    pzdrv_seq #(.CNT_W(CNT_W), .PULSE_W(PULSE_W), .DT_W(DT_W)) u_pzdrv_seq (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .start_i(start_i),
        .period_i(period_i), .duty_i(duty_i), .offset_i(offset_i),
        .reverse_i(reverse_i), .deadtime_i(deadtime_i), .pulses_i(pulses_i),
        .hs_o(hs_o), .ls_o(ls_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_run, m_done, m_cnt, m_per, m_duty, m_off, m_rev, m_dt, m_rem;
    int l_arm[4], l_side[4], l_tmr[4], l_hs[4], l_ls[4];

    always @(posedge clk) begin : model
        int en, la, lb, pb, want;
        if (!rst_n) begin
            m_run = 0; m_done = 0; m_cnt = 0; m_per = 2; m_duty = 0;
            m_off = 0; m_rev = 0; m_dt = 0; m_rem = 0;
            for (int i = 0; i < 4; i++) begin
                l_arm[i] = 0; l_side[i] = 0; l_tmr[i] = 0; l_hs[i] = 0; l_ls[i] = 0;
            end
        end else begin
            en = (m_run != 0 && !standby_i) ? 1 : 0;
            la = (m_cnt < m_duty) ? 1 : 0;
            pb = m_rev ? (m_cnt + m_off) % m_per : (m_cnt - m_off + m_per) % m_per;
            lb = (pb < m_duty) ? 1 : 0;
            for (int i = 0; i < 4; i++) begin
                want = ((i < 2) ? la : lb) ^ (i % 2);
                l_hs[i] = 0; l_ls[i] = 0;
                if (en == 0) begin
                    l_arm[i] = 0; l_tmr[i] = 0; l_side[i] = want;
                end else if (l_arm[i] == 0 || want != l_side[i]) begin
                    l_arm[i] = 1; l_side[i] = want; l_tmr[i] = m_dt;
                end else if (l_tmr[i] > 0) begin
                    l_tmr[i]--;
                end else begin
                    l_hs[i] = want; l_ls[i] = 1 - want;
                end
            end
            m_done = 0;
            if (m_run == 0) begin
                if (start_i && !standby_i && pulses_i != 0) begin
                    m_run = 1; m_cnt = 0; m_rem = int'(pulses_i);
                    m_per = (period_i < 2) ? 2 : int'(period_i);
                    m_duty = int'(duty_i);
                    m_off = (int'(offset_i) >= m_per) ? 0 : int'(offset_i);
                    m_rev = int'(reverse_i); m_dt = int'(deadtime_i);
                end
            end else if (standby_i) begin
                m_run = 0;
            end else if (m_cnt == m_per - 1) begin
                if (m_rem == 1) begin
                    m_run = 0; m_done = 1;
                end else begin
                    m_rem--; m_cnt = 0;
                    m_per = (period_i < 2) ? 2 : int'(period_i);
                    m_duty = int'(duty_i);
                    m_off = (int'(offset_i) >= m_per) ? 0 : int'(offset_i);
                    m_rev = int'(reverse_i); m_dt = int'(deadtime_i);
                end
            end else begin
                m_cnt++;
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always begin : compare
        int ehs, els, ahs, als;
        @(posedge clk);
        #3;
        if (rst_n && !finished) begin
            ehs = 0; els = 0;
            for (int i = 0; i < 4; i++) begin
                ehs |= ((l_hs[i] != 0 && !standby_i) ? 1 : 0) << i;
                els |= ((l_ls[i] != 0 && !standby_i) ? 1 : 0) << i;
            end
            ahs = int'(hs_o); als = int'(ls_o);
            chk(ahs == ehs, cur_req, "hs_o", ahs, ehs);
            chk(als == els, cur_req, "ls_o", als, els);
            chk(int'(busy_o) == m_run, cur_req, "busy_o", int'(busy_o), m_run);
            chk(int'(done_o) == m_done, cur_req, "done_o", int'(done_o), m_done);
            chk((hs_o & ls_o) == 4'b0, "R6", "hs&ls overlap", int'(hs_o & ls_o), 0);
        end
    end

    task automatic setup(input int per, input int duty, input int off, input int rev, input int dt, input int n);
        period_i = CNT_W'(per); duty_i = CNT_W'(duty); offset_i = CNT_W'(off);
        reverse_i = rev[0]; deadtime_i = DT_W'(dt); pulses_i = PULSE_W'(n);
    endtask

    // Starts a run at a negedge and counts busy cycles; kind 1 = extra start,
    // 2 = period change, 3 = standby, applied at busy cycle poke_at.
    task automatic run_count(input int exp_cyc, input int exp_done, input string req,
                             input int kind, input int poke_at, input int poke_val);
        int c = 0;
        int d = 0;
        int guard = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
        while (busy_o && guard < 5000) begin
            c++;
            if (done_o) d++;
            start_i = (kind == 1 && c == poke_at);
            if (kind == 2 && c == poke_at) period_i = CNT_W'(poke_val);
            if (kind == 3 && c == poke_at) standby_i = 1'b1;
            @(negedge clk);
            guard++;
        end
        start_i = 1'b0;
        if (done_o) d++;
        chk(c == exp_cyc, req, "busy cycles", c, exp_cyc);
        chk(d == exp_done, req, "done pulses", d, exp_done);
        @(negedge clk);
        chk(hs_o == 4'b0 && ls_o == 4'b0, "R9", "outputs after stop", int'({hs_o, ls_o}), 0);
        chk(done_o == 1'b0, "R8", "done is one cycle", int'(done_o), 0);
        standby_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog R8 actual=timeout expected=finish");
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk(hs_o == 4'b0 && ls_o == 4'b0, "R1", "outputs after reset", int'({hs_o, ls_o}), 0);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1", "status after reset", int'({busy_o, done_o}), 0);

        cur_req = "R4";
        setup(8, 3, 2, 0, 1, 4);
        run_count(32, 1, "R8", 0, 0, 0);

        cur_req = "R5";
        setup(10, 5, 3, 1, 0, 3);
        run_count(30, 1, "R5", 0, 0, 0);
        setup(6, 2, 9, 0, 0, 2);
        run_count(12, 1, "R5", 0, 0, 0);

        cur_req = "R3";
        setup(1, 1, 0, 0, 0, 5);
        run_count(10, 1, "R3", 0, 0, 0);

        cur_req = "R2";
        setup(8, 3, 1, 0, 0, 0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R2", "zero pulse start ignored", int'(busy_o), 0);
        setup(6, 3, 1, 0, 0, 3);
        run_count(18, 1, "R2", 1, 3, 0);

        cur_req = "R11";
        setup(8, 4, 2, 0, 0, 3);
        run_count(16, 1, "R11", 2, 3, 4);

        cur_req = "R7";
        setup(16, 8, 4, 0, 7, 3);
        run_count(48, 1, "R7", 0, 0, 0);
        setup(12, 2, 5, 1, 7, 2);
        run_count(24, 1, "R7", 0, 0, 0);

        cur_req = "R10";
        setup(8, 4, 2, 0, 1, 5);
        run_count(3, 0, "R10", 3, 3, 0);
        standby_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R10", "start in standby ignored", int'(busy_o), 0);
        chk(hs_o == 4'b0 && ls_o == 4'b0, "R10", "outputs in standby", int'({hs_o, ls_o}), 0);
        standby_i = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule